// File: doc/BRIEF.md
# Byte-Wide EEPROM Access and Record Loader

This block sits between a host register interface and an external byte-wide EEPROM reached through a request/acknowledge byte port. The host can read one EEPROM byte into a data register, or write the low byte of that register into the EEPROM. For both it sets a bit in the command register, and the hardware clears the bit once the access is done.

The block can also run an autonomous burst. The burst walks the EEPROM from a shared byte pointer and parses 6-byte records. Each record holds a 16-bit little-endian target address followed by a 32-bit little-endian data word. Each complete record becomes one write on a 24-bit-address, 32-bit-data memory port. The upper nine bits of that address come from a base register. The lower fifteen bits come from the record, and the record's top address bit is dropped. Single accesses and bursts share the pointer, so a burst resumes right after whatever was touched last.

Host register map (3-bit `reg_addr`): 0 = command, 1 = EEPROM address, 2 = data, 3 = base, 4 = burst-start. Registers are written with a one-cycle `reg_wr` strobe and read combinationally on `reg_rdata`.

Top module: `eeprom_loader`

## Requirements
- R1: After reset every register reads 0, `ee_req` is low and `mem_we` is low.
- R2: Writing command bit 1 as 1 starts a read of the EEPROM byte at the address register. The byte lands in the data register on the acknowledge edge, and bit 1 reads 0 from that edge on.
- R3: Writing command bit 0 as 1 writes the data register's byte to the EEPROM at the address register with `ee_wr` high. Bit 0 clears on the acknowledge edge.
- R4: When command bits 0 and 1 are both pending, the write is performed before the read.
- R5: A burst started after reset, before any single access, fetches its first byte from EEPROM address 0.
- R6: Otherwise a burst begins at the address following the last byte accessed, wrapping to 0.
- R7: Each complete record produces one `mem_we` pulse, one cycle after the acknowledge of its sixth byte. Byte 0 is the address low byte, byte 1 the address high byte, and bytes 2 to 5 the data from least to most significant. `mem_addr` = {base[8:0], record address[14:0]}.
- R8: A record address of 0xFFFF ends the burst after its second byte, and no memory write is issued for it.
- R9: A burst ends after reading the last EEPROM address, and a partial record is not written.
- R10: A single access requested while a burst runs is performed only after the burst ends.
- R11: Writing 1 to burst-start bit 0 starts a burst. The bit reads 1 while the burst runs and is cleared by hardware at its end.
- R12: Register read-back is zero-extended: the address register holds EE_AW bits, the data register 8 bits and the base register 9 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| ee_req | output | 1 | EEPROM byte request, held until acknowledged |
| ee_wr | output | 1 | Request is a write |
| ee_addr | output | EE_AW | EEPROM byte address |
| ee_wdata | output | 8 | EEPROM write byte |
| ee_ack | input | 1 | One-cycle acknowledge; read byte valid with it |
| ee_rdata | input | 8 | EEPROM read byte |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 24 | Memory write address |
| mem_wdata | output | 32 | Memory write data |

## Verification
A single access completes on the clock edge where `ee_ack` is sampled high, so the command bit and the data register change on that same edge. A memory write appears one cycle after the acknowledge of a record's sixth byte. Neither result has a fixed delay from the host write, because the EEPROM model answers only after a latency. The bench therefore polls the command and burst-start registers until they read 0, within a bound. It then compares the data register, the EEPROM model contents and the logged memory writes, and it checks the logged order of EEPROM acknowledges against addresses computed from the record layout.

// File: rtl/eel_pkg.sv
package eel_pkg;
  localparam int MEM_AW = 24;
  localparam int BASE_W = 9;
  localparam int LOW_W  = MEM_AW - BASE_W;
  localparam int REC_BYTES = 6;

  localparam logic [2:0] RA_CTRL  = 3'd0;
  localparam logic [2:0] RA_ADDR  = 3'd1;
  localparam logic [2:0] RA_DATA  = 3'd2;
  localparam logic [2:0] RA_BASE  = 3'd3;
  localparam logic [2:0] RA_BURST = 3'd4;

  typedef enum logic [1:0] {ST_IDLE, ST_SGL, ST_BRST} eng_st_t;

  // Memory address of a record: base on top, low bits from the record.
  function automatic logic [MEM_AW-1:0] rec_mem_addr(input logic [BASE_W-1:0] base,
                                                     input logic [15:0] rec);
    return {base, rec[LOW_W-1:0]};
  endfunction

  function automatic logic rec_is_term(input logic [15:0] rec);
    return rec == 16'hFFFF;
  endfunction

  function automatic logic [2:0] next_idx(input logic [2:0] idx);
    return (idx == 3'(REC_BYTES - 1)) ? 3'd0 : idx + 3'd1;
  endfunction
endpackage

// File: rtl/eel_regs.sv
module eel_regs
  import eel_pkg::*;
#(
  parameter int EE_AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              wr_done,
  input  logic              rd_done,
  input  logic [7:0]        rd_byte,
  input  logic              burst_done,
  output logic              pend_wr,
  output logic              pend_rd,
  output logic              burst_q,
  output logic [EE_AW-1:0]  addr_q,
  output logic [7:0]        data_q,
  output logic [BASE_W-1:0] base_q
);
  logic set_ctrl, set_burst;
  assign set_ctrl  = reg_wr && (reg_addr == RA_CTRL);
  assign set_burst = reg_wr && (reg_addr == RA_BURST) && reg_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_wr <= 1'b0;
      pend_rd <= 1'b0;
      burst_q <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
      base_q  <= '0;
    end else begin
      pend_wr <= (pend_wr && !wr_done) || (set_ctrl && reg_wdata[0]);
      pend_rd <= (pend_rd && !rd_done) || (set_ctrl && reg_wdata[1]);
      burst_q <= (burst_q && !burst_done) || set_burst;
      if (reg_wr && reg_addr == RA_ADDR) addr_q <= reg_wdata[EE_AW-1:0];
      if (rd_done)
        data_q <= rd_byte;
      else if (reg_wr && reg_addr == RA_DATA)
        data_q <= reg_wdata[7:0];
      if (reg_wr && reg_addr == RA_BASE) base_q <= reg_wdata[BASE_W-1:0];
    end
  end

  always_comb begin
    case (reg_addr)
      RA_CTRL:  reg_rdata = {30'd0, pend_rd, pend_wr};
      RA_ADDR:  reg_rdata = 32'(addr_q);
      RA_DATA:  reg_rdata = 32'(data_q);
      RA_BASE:  reg_rdata = 32'(base_q);
      RA_BURST: reg_rdata = {31'd0, burst_q};
      default:  reg_rdata = 32'd0;
    endcase
  end
endmodule

// File: rtl/eel_seq.sv
module eel_seq
  import eel_pkg::*;
#(
  parameter int EE_AW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pend_wr,
  input  logic             pend_rd,
  input  logic             burst_q,
  input  logic [EE_AW-1:0] addr_q,
  input  logic [7:0]       data_q,
  input  logic             ee_ack,
  input  logic             rec_term,
  output logic             ee_req,
  output logic             ee_wr,
  output logic [EE_AW-1:0] ee_addr,
  output logic [7:0]       ee_wdata,
  output logic             wr_done,
  output logic             rd_done,
  output logic             burst_done,
  output logic             burst_act,
  output logic             byte_vld,
  output logic [2:0]       byte_idx
);
  eng_st_t          st_q;
  logic [EE_AW-1:0] cur_q, next_ptr_q;
  logic             fresh_q, op_wr_q;
  logic             at_end, brst_stop;

  assign ee_req     = (st_q != ST_IDLE);
  assign ee_wr      = (st_q == ST_SGL) && op_wr_q;
  assign ee_addr    = cur_q;
  assign ee_wdata   = data_q;
  assign burst_act  = (st_q == ST_BRST);
  assign byte_vld   = burst_act && ee_ack;
  assign wr_done    = (st_q == ST_SGL) && ee_ack && op_wr_q;
  assign rd_done    = (st_q == ST_SGL) && ee_ack && !op_wr_q;
  assign at_end     = (cur_q == {EE_AW{1'b1}});
  assign brst_stop  = byte_vld && (at_end || rec_term);
  assign burst_done = brst_stop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      cur_q      <= '0;
      next_ptr_q <= '0;
      fresh_q    <= 1'b1;
      op_wr_q    <= 1'b0;
      byte_idx   <= '0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (burst_q) begin
            st_q     <= ST_BRST;
            cur_q    <= fresh_q ? '0 : next_ptr_q;
            byte_idx <= '0;
          end else if (pend_wr || pend_rd) begin
            st_q    <= ST_SGL;
            cur_q   <= addr_q;
            op_wr_q <= pend_wr;
          end
        end
        ST_SGL: begin
          if (ee_ack) begin
            st_q       <= ST_IDLE;
            next_ptr_q <= cur_q + 1'b1;
            fresh_q    <= 1'b0;
          end
        end
        ST_BRST: begin
          if (brst_stop) begin
            st_q       <= ST_IDLE;
            next_ptr_q <= cur_q + 1'b1;
            fresh_q    <= 1'b0;
          end else if (byte_vld) begin
            cur_q    <= cur_q + 1'b1;
            byte_idx <= next_idx(byte_idx);
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/eel_asm.sv
module eel_asm
  import eel_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_vld,
  input  logic [2:0]        byte_idx,
  input  logic [7:0]        byte_data,
  input  logic [BASE_W-1:0] base_q,
  output logic              rec_term,
  output logic              mem_we,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [31:0]       mem_wdata
);
  logic [7:0]  lo_q, hi_q;
  logic [23:0] dlo_q;

  assign rec_term = byte_vld && (byte_idx == 3'd1) && rec_is_term({byte_data, lo_q});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q      <= '0;
      hi_q      <= '0;
      dlo_q     <= '0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      mem_we <= 1'b0;
      if (byte_vld) begin
        case (byte_idx)
          3'd0: lo_q <= byte_data;
          3'd1: hi_q <= byte_data;
          3'd2: dlo_q[7:0]   <= byte_data;
          3'd3: dlo_q[15:8]  <= byte_data;
          3'd4: dlo_q[23:16] <= byte_data;
          3'd5: begin
            mem_we    <= 1'b1;
            mem_addr  <= rec_mem_addr(base_q, {hi_q, lo_q});
            mem_wdata <= {byte_data, dlo_q};
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/eeprom_loader.sv
module eeprom_loader
  import eel_pkg::*;
#(
  parameter int EE_AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              ee_req,
  output logic              ee_wr,
  output logic [EE_AW-1:0]  ee_addr,
  output logic [7:0]        ee_wdata,
  input  logic              ee_ack,
  input  logic [7:0]        ee_rdata,
  output logic              mem_we,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [31:0]       mem_wdata
);
  // Internal events, named for the checker.
  logic              wr_done, rd_done, burst_done, burst_act;
  logic              pend_wr, pend_rd, burst_q, rec_term, byte_vld;
  logic [2:0]        byte_idx;
  logic [EE_AW-1:0]  addr_q;
  logic [7:0]        data_q;
  logic [BASE_W-1:0] base_q;

  eel_regs #(.EE_AW(EE_AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .wr_done(wr_done),
    .rd_done(rd_done), .rd_byte(ee_rdata), .burst_done(burst_done),
    .pend_wr(pend_wr), .pend_rd(pend_rd), .burst_q(burst_q),
    .addr_q(addr_q), .data_q(data_q), .base_q(base_q)
  );

  eel_seq #(.EE_AW(EE_AW)) u_seq (
    .clk(clk), .rst_n(rst_n), .pend_wr(pend_wr), .pend_rd(pend_rd),
    .burst_q(burst_q), .addr_q(addr_q), .data_q(data_q), .ee_ack(ee_ack),
    .rec_term(rec_term), .ee_req(ee_req), .ee_wr(ee_wr), .ee_addr(ee_addr),
    .ee_wdata(ee_wdata), .wr_done(wr_done), .rd_done(rd_done),
    .burst_done(burst_done), .burst_act(burst_act), .byte_vld(byte_vld),
    .byte_idx(byte_idx)
  );

  eel_asm u_asm (
    .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_idx(byte_idx),
    .byte_data(ee_rdata), .base_q(base_q), .rec_term(rec_term),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );
endmodule

// File: rtl/eel_chk.sv
module eel_chk
  import eel_pkg::*;
#(
  parameter int EE_AW = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [2:0]        reg_addr,
  input logic [31:0]       reg_wdata,
  input logic              ee_req,
  input logic              ee_ack,
  input logic              ee_wr,
  input logic [EE_AW-1:0]  ee_addr,
  input logic              mem_we,
  input logic [MEM_AW-1:0] mem_addr,
  input logic              pend_wr,
  input logic              pend_rd,
  input logic              burst_q,
  input logic              burst_act,
  input logic [BASE_W-1:0] base_q
);
  logic host_sets_wr, host_sets_rd;
  assign host_sets_wr = reg_wr && reg_addr == RA_CTRL && reg_wdata[0];
  assign host_sets_rd = reg_wr && reg_addr == RA_CTRL && reg_wdata[1];

  // R3: an acknowledged write clears the command bit
  a_r3_wr_bit_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ee_req && ee_ack && ee_wr && !host_sets_wr |=> !pend_wr);

  // R2: an acknowledged single read clears the command bit
  a_r2_rd_bit_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ee_req && ee_ack && !ee_wr && !burst_act && !host_sets_rd |=> !pend_rd);

  // R2: a request stays up with a steady address until acknowledged
  a_r2_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    ee_req && !ee_ack |=> ee_req && $stable(ee_addr));

  // R7: memory address top bits come from the base register
  a_r7_base_bits: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_addr[MEM_AW-1:LOW_W] == $past(base_q));

  // R7: records take six bytes, so writes never come back to back
  a_r7_we_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);

  // R10: no pending single access is consumed while a burst runs
  a_r10_single_held: assert property (@(posedge clk) disable iff (!rst_n)
    burst_act |=> !$fell(pend_wr) && !$fell(pend_rd));

  // R11: the burst-start bit is still set when the burst engine begins
  a_r11_start_bit_set: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(burst_act) |-> burst_q);
endmodule

bind eeprom_loader eel_chk #(.EE_AW(EE_AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .ee_req(ee_req), .ee_ack(ee_ack), .ee_wr(ee_wr),
  .ee_addr(ee_addr), .mem_we(mem_we), .mem_addr(mem_addr),
  .pend_wr(pend_wr), .pend_rd(pend_rd), .burst_q(burst_q),
  .burst_act(burst_act), .base_q(base_q)
);

// File: tb/eeprom_loader_tb.sv
`timescale 1ns/1ps
module eeprom_loader_tb;
  localparam int AW  = 8;
  localparam int LAT = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        ee_req, ee_wr, ee_ack = 1'b0;
  logic [AW-1:0] ee_addr;
  logic [7:0]  ee_wdata, ee_rdata = '0;
  logic        mem_we;
  logic [23:0] mem_addr;
  logic [31:0] mem_wdata;

  int checks = 0, failures = 0;
  bit finished = 0;

  logic [7:0]  eemem [256];
  int          ack_n = 0;
  logic [7:0]  ack_addr [512];
  logic        ack_wr [512];
  int          mw_n = 0;
  logic [23:0] mw_addr [32];
  logic [31:0] mw_data [32];

  always #4 clk = ~clk;

  eeprom_loader #(.EE_AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ee_req(ee_req),
    .ee_wr(ee_wr), .ee_addr(ee_addr), .ee_wdata(ee_wdata), .ee_ack(ee_ack),
    .ee_rdata(ee_rdata), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata)
  );

  // EEPROM model: acknowledges after LAT cycles of held request.
  initial begin
    int cnt = 0;
    forever begin
      @(negedge clk);
      ee_ack = 1'b0;
      if (ee_req && rst_n) begin
        if (cnt == LAT) begin
          ee_ack = 1'b1;
          cnt = 0;
          if (ack_n < 512) begin
            ack_addr[ack_n] = ee_addr;
            ack_wr[ack_n] = ee_wr;
          end
          ack_n++;
          if (ee_wr) eemem[ee_addr] = ee_wdata;
          else ee_rdata = eemem[ee_addr];
        end else cnt++;
      end else cnt = 0;
    end
  end

  // Memory write monitor
  initial begin
    forever begin
      @(negedge clk);
      if (mem_we && mw_n < 32) begin
        mw_addr[mw_n] = mem_addr;
        mw_data[mw_n] = mem_wdata;
        mw_n++;
      end
    end
  end

  function automatic logic [15:0] rec_a(int k);
    logic [15:0] v = 16'(k * 16'h1111 + 16'h0123);
    if (k % 2 == 1) v = v ^ 16'h8000;
    return v;
  endfunction

  function automatic logic [31:0] rec_d(int k);
    return 32'(32'h9E3779B9 * (k + 1));
  endfunction

  function automatic logic [23:0] exp_maddr(int base, logic [15:0] a);
    return 24'((base << 15) | (a & 16'h7FFF));
  endfunction

  task automatic put_rec(int at, int k);
    logic [15:0] a = rec_a(k);
    logic [31:0] d = rec_d(k);
    eemem[at]   = a[7:0];
    eemem[at+1] = a[15:8];
    for (int b = 0; b < 4; b++) eemem[at+2+b] = d[8*b +: 8];
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_zero(logic [2:0] a);
    logic [31:0] v;
    for (int i = 0; i < 3000; i++) begin
      rd_reg(a, v);
      if (v == 0) return;
    end
  endtask

  task automatic clear_logs();
    ack_n = 0;
    mw_n = 0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    for (int i = 0; i < 256; i++) eemem[i] = 8'((i * 37 + 11) & 8'hFF);
    for (int j = 0; j < 5; j++) put_rec(6 * j, j);
    eemem[30] = 8'hFF; eemem[31] = 8'hFF;
    for (int j = 0; j < 9; j++) put_rec(201 + 6 * j, 10 + j);
    put_rec(51, 21);
    for (int i = 57; i <= 60; i++) eemem[i] = 8'hFF;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int r = 0; r < 5; r++) begin
      rd_reg(3'(r), v);
      check("R1 reg reset", v, 0);
    end
    check("R1 ee_req", 32'(ee_req), 0);
    check("R1 mem_we", 32'(mem_we), 0);

    // R12 read-back widths
    wr_reg(3'd1, 32'hFFFF_FFFF); rd_reg(3'd1, v); check("R12 addr", v, 32'hFF);
    wr_reg(3'd2, 32'h0000_1234); rd_reg(3'd2, v); check("R12 data", v, 32'h34);
    wr_reg(3'd3, 32'hFFFF_FFFF); rd_reg(3'd3, v); check("R12 base", v, 32'h1FF);

    // Burst 1 from reset, with a single read queued during it
    wr_reg(3'd1, 200);
    wr_reg(3'd3, 32'h0AB);
    clear_logs();
    wr_reg(3'd4, 1);
    rd_reg(3'd4, v); check("R11 busy", v, 1);
    wr_reg(3'd0, 2);
    wait_zero(3'd4);
    wait_zero(3'd0);
    check("R5 first addr", 32'(ack_addr[0]), 0);
    check("R8 stop at term", 32'(ack_addr[31]), 31);
    check("R10 single after burst", 32'(ack_addr[32]), 200);
    check("R10 ack count", ack_n, 33);
    check("R7 write count b1", mw_n, 5);
    for (int j = 0; j < 5; j++) begin
      check("R7 addr b1", 32'(mw_addr[j]), 32'(exp_maddr(32'h0AB, rec_a(j))));
      check("R7 data b1", mw_data[j], rec_d(j));
    end
    rd_reg(3'd2, v); check("R2 read data", v, 32'(eemem[200]));

    // Burst 2: continues at 201, runs into the end of the EEPROM
    wr_reg(3'd3, 32'h155);
    clear_logs();
    wr_reg(3'd4, 1);
    wait_zero(3'd4);
    check("R6 resume addr", 32'(ack_addr[0]), 201);
    check("R9 ack count", ack_n, 55);
    check("R9 last addr", 32'(ack_addr[54]), 255);
    check("R9 write count", mw_n, 9);
    for (int j = 0; j < 9; j++) begin
      check("R7 addr b2", 32'(mw_addr[j]), 32'(exp_maddr(32'h155, rec_a(10 + j))));
      check("R7 data b2", mw_data[j], rec_d(10 + j));
    end

    // Single write
    wr_reg(3'd1, 210);
    wr_reg(3'd2, 32'hA5);
    clear_logs();
    wr_reg(3'd0, 1);
    wait_zero(3'd0);
    check("R3 eeprom byte", 32'(eemem[210]), 32'hA5);
    check("R3 write flag", 32'(ack_wr[0]), 1);
    check("R3 ack count", ack_n, 1);

    // Both bits: write then read
    wr_reg(3'd1, 50);
    wr_reg(3'd2, 32'h3C);
    clear_logs();
    wr_reg(3'd0, 3);
    wait_zero(3'd0);
    check("R4 first is write", 32'(ack_wr[0]), 1);
    check("R4 second is read", 32'(ack_wr[1]), 0);
    check("R4 count", ack_n, 2);
    rd_reg(3'd2, v); check("R4 read back", v, 32'h3C);

    // Burst 3: one record with address MSB set, then terminator
    wr_reg(3'd3, 32'h1FF);
    clear_logs();
    wr_reg(3'd4, 1);
    wait_zero(3'd4);
    check("R6 resume after single", 32'(ack_addr[0]), 51);
    check("R8 ack count b3", ack_n, 8);
    check("R8 write count b3", mw_n, 1);
    check("R7 msb dropped", 32'(mw_addr[0]), 32'(exp_maddr(32'h1FF, rec_a(21))));
    check("R7 data b3", mw_data[0], rec_d(21));

    // Burst 4: terminator right away
    clear_logs();
    wr_reg(3'd4, 1);
    wait_zero(3'd4);
    check("R8 start b4", 32'(ack_addr[0]), 59);
    check("R8 ack count b4", ack_n, 2);
    check("R8 no write b4", mw_n, 0);

    finish_run();
  end
endmodule